// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over several clock cycles. It uses one adder of operand width plus a carry bit and a single product register of twice that width. The multiplier operand is loaded into the low half of the product register. Each cycle, the lowest bit of the register decides whether the multiplicand is added into the upper half. The whole register then shifts right by one, so multiplier bits leave at the bottom while product bits fill in from the top. A full multiply takes one step per multiplier bit.

A mode input chosen at start selects unsigned or two's-complement operation. In signed mode the upper half is treated as a signed partial sum: the bit shifted into the top is the true sign of that sum. If the multiplier's top bit is set, the final step subtracts the multiplicand instead of adding it. The finished double-width result appears as a high word and a low word. These words hold steady until the next multiply completes.

A host raises `start` with the operands and mode while the unit is idle. It then waits for the one-cycle `done` pulse and reads the two result words.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and right after it, `busy` and `done` are 0 and `prodHi`/`prodLo` are 0.
- R2: A `start` seen on a clock edge while `busy` is 0 is accepted. `busy` is 1 from that edge for exactly WIDTH cycles.
- R3: `done` is 1 for exactly one cycle, the cycle right after `busy` falls. `busy` and `done` are never 1 together.
- R4: With `signedMode` = 0 at the accepted start, {`prodHi`,`prodLo`} equals `opA` × `opB` with both operands read as unsigned.
- R5: With `signedMode` = 1 at the accepted start, {`prodHi`,`prodLo`} equals the 64-bit two's-complement product of `opA` and `opB`. This holds for a negative multiplier (final step subtracts) and for the most negative operand value.
- R6: While `busy` is 1, the unit ignores `start`, `opA`, `opB` and `signedMode`, as it does for any operand change after the accepting edge. The running multiply keeps its result and its length of WIDTH busy cycles.
- R7: `prodHi`/`prodLo` change only on the edge where `done` rises. At all other times, including through the next multiply, they hold the last result.
- R8: In unsigned mode the adder's carry-out becomes the top product bit, so 0xFFFFFFFF × 0xFFFFFFFF gives `prodHi` = 0xFFFFFFFE and `prodLo` = 0x00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a multiply; taken only when not busy |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opA | input | WIDTH | Multiplicand |
| opB | input | WIDTH | Multiplier |
| busy | output | 1 | High while the step sequence runs |
| done | output | 1 | One-cycle pulse when a result is ready |
| prodHi | output | WIDTH | Upper half of the product |
| prodLo | output | WIDTH | Lower half of the product |

## Verification
A start accepted on edge k raises `busy` for the following WIDTH cycles. The result and the `done` pulse appear on edge k+WIDTH, and `done` is gone one cycle later. The bench drives inputs on falling edges and samples there too. It counts `busy` cycles at each falling edge, expects `done` and the new product words exactly on the falling edge after `busy` drops, and then expects `done` clear one cycle later. Result words are compared by a monitor that pops predicted products in issue order. Midway through each multiply, the hold of the previous result is also checked.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // capture operands, clear upper half
    logic step;      // perform one add/shift iteration
    logic lastStep;  // this iteration consumes the multiplier's top bit
  } mulStrobes_t;

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output mulStrobes_t strobes
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] stepCnt;
  logic             accept;

  assign accept = start && !busyQ;

  always_comb begin
    strobes          = '0;
    strobes.load     = accept;
    strobes.step     = busyQ;
    strobes.lastStep = busyQ && (stepCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      stepCnt <= '0;
    end else begin
      doneQ <= strobes.lastStep;
      if (accept) begin
        busyQ   <= 1'b1;
        stepCnt <= '0;
      end else if (busyQ) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobes.lastStep) busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/shiftadd_mul_addsub.sv
module shiftadd_mul_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0] partial,  // sign/zero-extended upper half
  input  logic [WIDTH:0] mcand,    // sign/zero-extended multiplicand
  input  logic           enable,   // current multiplier bit
  input  logic           subtract,
  output logic [WIDTH:0] result
);

  logic [WIDTH:0] operand;

  always_comb begin
    if (!enable)       operand = '0;
    else if (subtract) operand = ~mcand;
    else               operand = mcand;
    result = partial + operand + {{WIDTH{1'b0}}, enable && subtract};
  end

endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobes_t      strobes,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] mcandReg;
  logic             sgnReg;
  logic [WIDTH-1:0] hiOut;
  logic [WIDTH-1:0] loOut;

  logic [WIDTH-1:0] upperHalf;
  logic             curBit;
  logic             doSub;
  logic [WIDTH:0]   extUpper;
  logic [WIDTH:0]   extMcand;
  logic [WIDTH:0]   stepSum;
  logic [PW-1:0]    nextProd;

  assign upperHalf = prodReg[PW-1:WIDTH];
  assign curBit    = prodReg[0];
  assign doSub     = sgnReg && strobes.lastStep;
  assign extUpper  = {sgnReg && upperHalf[WIDTH-1], upperHalf};
  assign extMcand  = {sgnReg && mcandReg[WIDTH-1], mcandReg};

  shiftadd_mul_addsub #(.WIDTH(WIDTH)) adder (
    .partial (extUpper),
    .mcand   (extMcand),
    .enable  (curBit),
    .subtract(doSub),
    .result  (stepSum)
  );

  // Extra adder bit (carry or true sign) enters at the top; multiplier bit leaves at the bottom
  assign nextProd = {stepSum, prodReg[WIDTH-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodReg  <= '0;
      mcandReg <= '0;
      sgnReg   <= 1'b0;
      hiOut    <= '0;
      loOut    <= '0;
    end else if (strobes.load) begin
      prodReg  <= {{WIDTH{1'b0}}, opB};
      mcandReg <= opA;
      sgnReg   <= signedMode;
    end else if (strobes.step) begin
      prodReg <= nextProd;
      if (strobes.lastStep) begin
        hiOut <= nextProd[PW-1:WIDTH];
        loOut <= nextProd[WIDTH-1:0];
      end
    end
  end

  assign prodHi = hiOut;
  assign prodLo = loOut;

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] prodHi,
  output logic [WIDTH-1:0] prodLo
);

  mulStrobes_t strobes;

  shiftadd_mul_ctrl #(.WIDTH(WIDTH)) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .strobes(strobes)
  );

  shiftadd_mul_dp #(.WIDTH(WIDTH)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .signedMode(signedMode),
    .opA       (opA),
    .opB       (opB),
    .prodHi    (prodHi),
    .prodLo    (prodLo)
  );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] prodHi,
  input logic [WIDTH-1:0] prodLo
);

  localparam int LW = $clog2(WIDTH + 2);

  logic [LW-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rstN |-> !busy && !done);

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R2, R6: a run lasts exactly WIDTH cycles, even with start raised mid-run
  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == LW'(WIDTH));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(prodHi) && $stable(prodLo));

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.WIDTH(WIDTH)) chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .prodHi(prodHi),
  .prodLo(prodLo)
);

// File: tb/shiftadd_mul_test.sv
module shiftadd_mul_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] prodHi;
  logic [W-1:0] prodLo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [2*W-1:0] expQ[$];
  string          tagQ[$];
  logic [2*W-1:0] lastRes = '0;

  always #4 clk = ~clk;  // 125 MHz

  shiftadd_mul #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .prodHi(prodHi), .prodLo(prodLo)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, bit sgn);
    logic [2*W-1:0] ea, eb;
    ea = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = sgn ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  // Monitor: compare each completed result with the oldest prediction
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "done with nothing pending", 64'(done), 64'd0);
        end else begin
          logic [2*W-1:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({prodHi, prodLo} == e, t, "product", {prodHi, prodLo}, e);
        end
      end
    end
  end

  task automatic runOp(logic [W-1:0] a, logic [W-1:0] b, bit sgn, string req, bit poke);
    int cnt;
    logic [2*W-1:0] e;
    e = model(a, b, sgn);
    @(negedge clk);
    opA = a; opB = b; signedMode = sgn; start = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(req);
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = ~b; signedMode = ~sgn;  // R6: changes after acceptance
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      if (cnt == 5)
        check({prodHi, prodLo} == lastRes, "R7", "hold during run", {prodHi, prodLo}, lastRes);
      if (poke && cnt == 8) begin
        start = 1'b1; opA = 32'h1234_5678; opB = 32'h0000_0003;
      end
      if (poke && cnt == 9) start = 1'b0;
      @(negedge clk);
    end
    check(cnt == W, poke ? "R6" : "R2", "busy cycles", 64'(cnt), 64'(W));
    check(done == 1'b1, "R3", "done after busy", 64'(done), 64'd1);
    lastRes = e;
    @(negedge clk);
    check(done == 1'b0, "R3", "done single cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check({prodHi, prodLo} == lastRes, "R7", "hold while idle", {prodHi, prodLo}, lastRes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {62'd0, busy, done}, 64'd0);
    check({prodHi, prodLo} == '0, "R1", "product in reset", {prodHi, prodLo}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {62'd0, busy, done}, 64'd0);

    runOp(32'd6, 32'd7, 1'b0, "R4", 1'b0);
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8", 1'b0);
    runOp(32'h8000_0001, 32'h0001_0003, 1'b0, "R4", 1'b0);
    runOp(32'd0, 32'hDEAD_BEEF, 1'b0, "R4", 1'b0);
    runOp(-32'sd4, 32'd5, 1'b1, "R5", 1'b0);
    runOp(32'd5, -32'sd4, 1'b1, "R5", 1'b0);
    runOp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5", 1'b0);
    runOp(32'h8000_0000, 32'h8000_0000, 1'b1, "R5", 1'b0);
    runOp(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R5", 1'b0);
    runOp(32'h7FFF_FFFF, 32'h8000_0001, 1'b1, "R5", 1'b0);
    runOp(32'hA5A5_1234, 32'h0F0F_F0F0, 1'b0, "R6", 1'b1);
    runOp(-32'sd123456, 32'h9ABC_DEF0, 1'b1, "R6", 1'b1);

    check(expQ.size() == 0, "R3", "results outstanding", 64'(expQ.size()), 64'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule